// File: doc/BRIEF.md
# Continuous Paged Flash Read Engine

This block fetches a run of bytes from a serial flash whose pages need not be a power of two in size (264, 528 or 1056 bytes, for example). A requester gives a linear byte offset, a byte count, the page size and the page-address shift. The engine splits the offset into a page number and a byte within that page using a sequential divider. It then builds the device address by shifting the page number left by the shift amount and adding the byte-within-page value.

With that address it opens one chip-select window on a byte-level SPI transaction port. It sends the continuous-read opcode, the three address bytes with the most significant first, and a fixed run of zero-valued don't-care bytes. Every byte exchanged after the header is passed to a valid/ready output stream. When the consumer holds off, the engine stops issuing SPI bytes and keeps chip select asserted. No status polling is done, and the device's internal page buffers are left untouched.

A separate byte engine serialises the bytes, and the requester chooses the SPI clock rate. Page size and shift are captured when a request is accepted.

Top module: `cflash_rd_engine`

## Requirements
- R1: After reset, chip select is high (inactive), `spi_go`, `out_valid` and `done` are low, and `req_ready` is high.
- R2: A request with length zero is accepted and answered with a `done` pulse in the cycle right after acceptance. Chip select never goes low and no SPI byte is issued.
- R3: The device address is ((offset / page_size) << page_shift) + (offset % page_size), truncated to 24 bits. This holds for pairs such as 256/8, 264/9, 528/10 and 1056/11.
- R4: The first byte of each transaction is the opcode 0xE8. It is followed by address bits 23:16, then 15:8, then 7:0.
- R5: After the address, exactly four bytes of value 0x00 are sent. The bytes returned while the 8-byte header is sent never reach the output stream.
- R6: After the header, exactly `req_len` further bytes are exchanged, each sent as 0x00. The returned bytes appear on `out_data` in the order they were received.
- R7: Chip select goes low before the first header byte and stays low, stalls included, until the last data byte has been accepted. It rises exactly once per nonzero request.
- R8: No new SPI byte is issued while a data byte is held on the output and has not been accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: `req_ready` is low for the whole of a transaction, and `req_valid` is ignored during that time.
- R11: `done` is a one-cycle pulse. It is raised together with the return of chip select to high, once the final data byte has been accepted.
- R12: `spi_go` stays high with `spi_tx` unchanged until `spi_done` is seen. Each `spi_done` completes one byte, with `spi_rx` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_offset | input | 24 | Linear byte offset in the flash |
| req_len | input | LEN_W | Number of bytes to read |
| page_size | input | PS_W | Page size in bytes, nonzero |
| page_shift | input | SH_W | Left shift applied to the page number |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_go | output | 1 | Byte exchange request, held until `spi_done` |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received, valid with `spi_done` |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the output byte |

## Verification
The bench uses the default parameters: a 16-bit length, an 11-bit page size, a 4-bit shift and four dummy bytes. With these values it can drive the largest non-power-of-two geometry, 1056-byte pages with shift 11, at offsets close to the top of the 24-bit address space. It can also check that a 256-byte page with shift 8 gives back the offset unchanged. Its SPI model answers with latency and tags every returned byte by its position. This shows that header responses are dropped and that data order survives throttled and long-stalled consumers.

// File: rtl/cfr_pkg.sv
// Shared constants and types for the continuous flash read engine.
// Assumes a 3-byte device address, as carried by the read command.
package cfr_pkg;
    localparam int          ADDR_BYTES = 3;
    localparam int          ADDR_W     = 8 * ADDR_BYTES;
    localparam logic [7:0]  READ_OPC   = 8'hE8;
    localparam logic [7:0]  DUMMY_BYTE = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_HDR,
        ST_DATA
    } state_t;
endpackage

// File: rtl/cfr_seq_div.sv
// Restoring divider, one quotient bit per cycle.
// Takes NUM_W cycles after start and then pulses valid for one cycle.
// Assumes den is nonzero and that start is not raised while a division is running.
module cfr_seq_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             valid_q;
    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   diff;
    logic             ge;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        rem_sh = {rem_q, quo_q[NUM_W-1]};
        diff   = rem_sh - {1'b0, den_q};
        ge     = (rem_sh >= {1'b0, den_q});
    end

    // Iteration: shift the partial remainder and record the quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                quo_q <= num;
                rem_q <= '0;
                den_q <= den;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_q <= {quo_q[NUM_W-2:0], ge};
                rem_q <= ge ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid = valid_q;
    assign quo   = quo_q;
    assign rem   = rem_q;

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && den_q != '0) |-> (rem_q < den_q)); // R3
endmodule

// File: rtl/cfr_addr_comp.sv
// Builds the device address from page number and byte-within-page.
// Purely combinational. Bits above ADDR_W are dropped.
module cfr_addr_comp #(
    parameter int ADDR_W = 24,
    parameter int DEN_W  = 11,
    parameter int SH_W   = 4
) (
    input  logic [ADDR_W-1:0] page_num,
    input  logic [DEN_W-1:0]  byte_in_page,
    input  logic [SH_W-1:0]   shift,
    output logic [ADDR_W-1:0] dev_addr
);
    // Shift the page number into place and add the in-page byte.
    always_comb begin
        dev_addr = (page_num << shift) + ADDR_W'(byte_in_page);
    end
endmodule

// File: rtl/cfr_hdr_mux.sv
// Picks the command header byte for a given header position:
// opcode, then the address high to low, then don't-care bytes.
module cfr_hdr_mux
    import cfr_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        hdr_byte
);
    // Position decode for the header sequence.
    always_comb begin
        hdr_byte = DUMMY_BYTE;
        if (idx == '0) begin
            hdr_byte = READ_OPC;
        end else if (int'(idx) <= ADDR_BYTES) begin
            hdr_byte = addr[8*(ADDR_BYTES - int'(idx)) +: 8];
        end
    end
endmodule

// File: rtl/cflash_rd_engine.sv
// Continuous read engine for a paged serial flash.
// Accepts one request at a time. It splits the offset with a sequential
// divider, sends the read header and then streams the data bytes out with
// backpressure. Assumes page_size is nonzero and that the SPI byte engine
// answers every spi_go with exactly one spi_done.
module cflash_rd_engine
    import cfr_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int PS_W    = 11,
    parameter int SH_W    = 4,
    parameter int DUMMY_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [PS_W-1:0]   page_size,
    input  logic [SH_W-1:0]   page_shift,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_go,
    output logic [7:0]        spi_tx,
    input  logic              spi_done,
    input  logic [7:0]        spi_rx,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready
);
    localparam int HDR_N = 1 + ADDR_BYTES + DUMMY_N;
    localparam int IDX_W = $clog2(HDR_N);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_N - 1);

    state_t            state_q;
    logic [ADDR_W-1:0] off_q;
    logic [LEN_W-1:0]  left_q;
    logic [PS_W-1:0]   ps_q;
    logic [SH_W-1:0]   sh_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              div_start_q;
    logic              go_q;
    logic [7:0]        tx_q;
    logic              cs_n_q;
    logic              ov_q;
    logic [7:0]        od_q;
    logic              done_q;

    logic              div_valid;
    logic [ADDR_W-1:0] div_quo;
    logic [PS_W-1:0]   div_rem;
    logic [ADDR_W-1:0] addr_w;
    logic [7:0]        hdr_byte_w;

    cfr_seq_div #(.NUM_W(ADDR_W), .DEN_W(PS_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start_q),
        .num   (off_q),
        .den   (ps_q),
        .valid (div_valid),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    cfr_addr_comp #(.ADDR_W(ADDR_W), .DEN_W(PS_W), .SH_W(SH_W)) u_addr (
        .page_num     (div_quo),
        .byte_in_page (div_rem),
        .shift        (sh_q),
        .dev_addr     (addr_w)
    );

    cfr_hdr_mux #(.IDX_W(IDX_W)) u_hdr (
        .idx      (idx_q),
        .addr     (addr_q),
        .hdr_byte (hdr_byte_w)
    );

    // Transaction sequencer: accept, divide, send the header, stream the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            off_q       <= '0;
            left_q      <= '0;
            ps_q        <= '0;
            sh_q        <= '0;
            addr_q      <= '0;
            idx_q       <= '0;
            div_start_q <= 1'b0;
            go_q        <= 1'b0;
            tx_q        <= '0;
            cs_n_q      <= 1'b1;
            ov_q        <= 1'b0;
            od_q        <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q      <= 1'b0;
            div_start_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            off_q       <= req_offset;
                            left_q      <= req_len;
                            ps_q        <= page_size;
                            sh_q        <= page_shift;
                            div_start_q <= 1'b1;
                            state_q     <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_valid) begin
                        addr_q  <= addr_w;
                        idx_q   <= '0;
                        cs_n_q  <= 1'b0;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (!go_q) begin
                        go_q <= 1'b1;
                        tx_q <= hdr_byte_w;
                    end else if (spi_done) begin
                        go_q <= 1'b0;
                        if (idx_q == HDR_LAST) begin
                            state_q <= ST_DATA;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (ov_q && out_ready) begin
                        ov_q <= 1'b0;
                    end
                    if (go_q) begin
                        if (spi_done) begin
                            go_q   <= 1'b0;
                            ov_q   <= 1'b1;
                            od_q   <= spi_rx;
                            left_q <= left_q - 1'b1;
                        end
                    end else if (!ov_q) begin
                        if (left_q != '0) begin
                            go_q <= 1'b1;
                            tx_q <= DUMMY_BYTE;
                        end else begin
                            cs_n_q  <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign spi_cs_n  = cs_n_q;
    assign spi_go    = go_q;
    assign spi_tx    = tx_q;
    assign out_valid = ov_q;
    assign out_data  = od_q;

    AST_GO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && !spi_done) |=> (go_q && $stable(tx_q))); // R12
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q && !out_ready) |=> (ov_q && $stable(od_q))); // R9
    AST_NO_ISSUE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q |-> !go_q); // R8
    AST_GO_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> !cs_n_q); // R7
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n_q && !go_q)); // R10
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cs_n_q && !ov_q && req_ready)); // R11
endmodule

// File: tb/cflash_rd_engine_tb.sv
module cflash_rd_engine_tb;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_offset = '0;
    logic [15:0] req_len = '0;
    logic [10:0] page_size = 11'd264;
    logic [3:0]  page_shift = 4'd9;
    logic        done;
    logic        spi_cs_n;
    logic        spi_go;
    logic [7:0]  spi_tx;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int seed = 0;
    int mode = 0;
    int ntx = 0;
    int nout = 0;
    int cs_rises = 0;
    int out_at_rise = 0;
    int cs_low_cnt = 0;
    int stall_err = 0;
    int hold_err = 0;
    int mcnt = 0;
    logic [7:0] tx_cap;
    logic [7:0] tx_log [0:255];
    logic [7:0] out_log [0:255];
    logic hold_prev = 1'b0;
    logic [7:0] hold_data = '0;
    logic cs_prev = 1'b1;

    always #4 clk = ~clk;

    cflash_rd_engine u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_offset (req_offset),
        .req_len    (req_len),
        .page_size  (page_size),
        .page_shift (page_shift),
        .done       (done),
        .spi_cs_n   (spi_cs_n),
        .spi_go     (spi_go),
        .spi_tx     (spi_tx),
        .spi_done   (spi_done),
        .spi_rx     (spi_rx),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready)
    );

    function automatic logic [7:0] pat(int k);
        return 8'((k * 29 + seed) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // SPI byte engine model: answers each spi_go after LAT cycles.
    always @(negedge clk) begin
        spi_done = 1'b0;
        if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin
                spi_done = 1'b1;
                spi_rx = pat(ntx);
                if (ntx < 256) tx_log[ntx] = tx_cap;
                ntx++;
            end
        end else if (spi_go && rst_n) begin
            tx_cap = spi_tx;
            mcnt = LAT;
        end
    end

    // Consumer and monitor: drives out_ready, records the stream, watches chip select.
    always @(negedge clk) begin
        cyc++;
        case (mode)
            1:       out_ready = (cyc % 3 == 0);
            2:       out_ready = (cyc % 24) >= 20;
            default: out_ready = 1'b1;
        endcase
        if (hold_prev && (!out_valid || out_data != hold_data)) hold_err++;
        hold_prev = out_valid && !out_ready;
        hold_data = out_data;
        if (out_valid && spi_go) stall_err++;
        if (out_valid && out_ready) begin
            if (nout < 256) out_log[nout] = out_data;
            nout++;
        end
        if (!spi_cs_n) cs_low_cnt++;
        if (!cs_prev && spi_cs_n) begin
            cs_rises++;
            out_at_rise = nout;
        end
        cs_prev = spi_cs_n;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic start_read(int off, int len, int ps, int sh, int m, int sd);
        @(negedge clk);
        ntx = 0; nout = 0; cs_rises = 0; out_at_rise = 0; cs_low_cnt = 0;
        stall_err = 0; hold_err = 0; seed = sd; mode = m;
        req_offset = 24'(off); req_len = 16'(len);
        page_size = 11'(ps); page_shift = 4'(sh);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_read(int off, int len, int ps, int sh);
        int ea;
        int zero_err;
        int data_err;
        wait_done();
        chk(done == 1'b1, "R11", "done pulse seen", int'(done), 1);
        chk(spi_cs_n == 1'b1, "R11", "cs high with done", int'(spi_cs_n), 1);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done lasts one cycle", int'(done), 0);
        ea = (((off / ps) << sh) + (off % ps)) & 32'hFFFFFF;
        chk(ntx == 8 + len, "R6", "spi byte count", ntx, 8 + len);
        chk(tx_log[0] == 8'hE8, "R4", "opcode byte", int'(tx_log[0]), 'hE8);
        chk(tx_log[1] == 8'(ea >> 16), "R3", "address 23:16", int'(tx_log[1]), (ea >> 16) & 255);
        chk(tx_log[2] == 8'(ea >> 8), "R3", "address 15:8", int'(tx_log[2]), (ea >> 8) & 255);
        chk(tx_log[3] == 8'(ea), "R3", "address 7:0", int'(tx_log[3]), ea & 255);
        zero_err = 0;
        for (int i = 4; i < 8; i++) if (tx_log[i] != 8'h00) zero_err++;
        chk(zero_err == 0, "R5", "dummy bytes zero", zero_err, 0);
        zero_err = 0;
        for (int i = 8; i < 8 + len && i < 256; i++) if (tx_log[i] != 8'h00) zero_err++;
        chk(zero_err == 0, "R6", "data-phase tx zero", zero_err, 0);
        chk(nout == len, "R6", "output byte count", nout, len);
        data_err = 0;
        for (int i = 0; i < len && i < 256; i++) if (out_log[i] != pat(8 + i)) data_err++;
        chk(data_err == 0, "R5", "stream skips header and keeps order", data_err, 0);
        chk(cs_rises == 1, "R7", "single cs window", cs_rises, 1);
        chk(out_at_rise == len, "R7", "cs held until last byte taken", out_at_rise, len);
        chk(stall_err == 0, "R8", "no spi byte while output held", stall_err, 0);
        chk(hold_err == 0, "R9", "held output stable", hold_err, 0);
    endtask

    task automatic t_reset();
        chk(spi_cs_n == 1'b1, "R1", "cs after reset", int'(spi_cs_n), 1);
        chk(spi_go == 1'b0, "R1", "go after reset", int'(spi_go), 0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_zero_len();
        start_read(5000, 0, 264, 9, 0, 3);
        chk(done == 1'b1, "R2", "done right after accept", int'(done), 1);
        repeat (12) @(negedge clk);
        chk(cs_low_cnt == 0, "R2", "cs never low", cs_low_cnt, 0);
        chk(ntx == 0, "R2", "no spi byte", ntx, 0);
    endtask

    task automatic t_busy_ignore();
        int rdy_err = 0;
        start_read(777, 6, 528, 10, 2, 11);
        repeat (3) @(negedge clk);
        req_offset = 24'd0; req_len = 16'd3; req_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (req_ready) rdy_err++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        req_offset = 24'd777; req_len = 16'd6;
        chk(rdy_err == 0, "R10", "req_ready low while busy", rdy_err, 0);
        finish_read(777, 6, 528, 10);
        repeat (60) @(negedge clk);
        chk(ntx == 14, "R10", "no second transaction", ntx, 14);
        chk(cs_rises == 1, "R10", "no second cs window", cs_rises, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        start_read(1000, 5, 264, 9, 0, 1);      finish_read(1000, 5, 264, 9);
        start_read(12345, 12, 528, 10, 1, 2);   finish_read(12345, 12, 528, 10);
        start_read(8650000, 3, 1056, 11, 2, 5); finish_read(8650000, 3, 1056, 11);
        start_read(4660, 4, 256, 8, 0, 7);      finish_read(4660, 4, 256, 8);
        start_read(263, 3, 264, 9, 1, 9);       finish_read(263, 3, 264, 9);
        t_zero_len();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule